// File: doc/BRIEF.md
# Programmable Integer and Fractional Clock Divider

This block produces a slower clock domain from a reference clock. A configuration word selects the divide ratio. It consists of a fractional-select bit and an N-bit divisor field. With the fractional-select bit low, the block counts reference cycles and divides by the divisor exactly. With the fractional-select bit high and the divisor's top bit low, a phase accumulator approximates the ratio 2^N / divisor.

The block has two outputs. The first is a one-reference-cycle enable pulse that marks the start of each output period. The second is a registered divided clock. A divisor of one routes the reference itself to the clock output. Two settings are flagged and keep the outputs quiet: a divisor of zero, and the fractional-select bit combined with a set top bit, which is not supported. A new setting is adopted only at the end of the current output period, so a reconfiguration never cuts a period short.

Top module: `clkdiv_top`

## Requirements
- R1: With `cfg_frac_en` = 0 and `cfg_div` = D (1 to 2^N-1), `tick_o` pulses exactly once every D reference cycles.
- R2: With `cfg_frac_en` = 0 and `cfg_div` = 1, `tick_o` is high in every cycle and `clk_o` follows the reference clock (high just after a rising edge, low just after a falling edge).
- R3: With `cfg_frac_en` = 0 and `cfg_div` = 2, `tick_o` pulses every second cycle and `clk_o` is high in one cycle of every two.
- R4: In integer mode with D >= 2, `clk_o` is high for floor(D/2) cycles of each D-cycle period, starting in the cycle where `tick_o` is high.
- R5: `cfg_div` = 0 in either mode makes `err_zero_o` high and holds `tick_o` and `clk_o` low.
- R6: With `cfg_frac_en` = 1 and `cfg_div[N-1]` = 0, `tick_o` pulses exactly `cfg_div` times in any window of 2^N consecutive cycles, and never in two consecutive cycles.
- R7: With `cfg_frac_en` = 1 and `cfg_div[N-1]` = 1 (non-zero), `err_unsup_o` is high, `err_zero_o` is low, and `tick_o` and `clk_o` stay low.
- R8: A change of `cfg_frac_en` or `cfg_div` takes effect only after the current output period has ended. The remaining ticks of the old period keep the old spacing.
- R9: While `rst` is high, `tick_o`, `clk_o`, `err_zero_o` and `err_unsup_o` are low. In the first cycle after `rst` falls, the inputs are sampled, and a running setting gives a `tick_o` pulse in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frac_en | input | 1 | Selects fractional accumulator operation |
| cfg_div | input | DIV_W | Divisor field |
| tick_o | output | 1 | One-cycle enable at each output period start |
| clk_o | output | 1 | Divided clock (reference itself when divisor is 1) |
| err_zero_o | output | 1 | Active setting has a zero divisor |
| err_unsup_o | output | 1 | Active setting requests the unsupported gated mode |

## Verification
The assertions assume that `cfg_frac_en` and `cfg_div` are driven synchronously to the reference and are held for at least one cycle. In fractional mode they also assume that the divisor's top bit is low before they rely on tick spacing. The bench changes the configuration only on falling edges. Before it measures anything, it waits longer than the longest possible old period. Each measurement window starts on an observed tick, so every integer window spans a whole number of periods and every fractional window spans exactly 2^N cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [2:0] {
        MD_IDLE  = 3'd0,
        MD_INT   = 3'd1,
        MD_FRAC  = 3'd2,
        MD_ZERO  = 3'd3,
        MD_UNSUP = 3'd4
    } div_mode_e;

    // Zero divisor wins over every other decode.
    function automatic div_mode_e pick_mode(input logic frac_sel,
                                            input logic top_bit,
                                            input logic is_zero);
        if (is_zero)
            return MD_ZERO;
        else if (!frac_sel)
            return MD_INT;
        else if (!top_bit)
            return MD_FRAC;
        else
            return MD_UNSUP;
    endfunction

    function automatic logic is_running(input div_mode_e m);
        return (m == MD_INT) || (m == MD_FRAC);
    endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_frac_en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             int_bound,
    input  logic             frac_bound,
    output div_mode_e        act_mode,
    output logic [DIV_W-1:0] act_div,
    output logic             load,
    output div_mode_e        nxt_mode,
    output logic [DIV_W-1:0] nxt_div
);

    always_comb begin
        nxt_mode = pick_mode(cfg_frac_en, cfg_div[DIV_W-1], cfg_div == '0);
        nxt_div  = cfg_div;
    end

    // Running modes adopt a new setting only at their period end;
    // idle and error modes re-sample every cycle.
    always_comb begin
        unique case (act_mode)
            MD_INT:  load = int_bound;
            MD_FRAC: load = frac_bound;
            default: load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= MD_IDLE;
            act_div  <= '0;
        end else if (load) begin
            act_mode <= nxt_mode;
            act_div  <= nxt_div;
        end
    end

    // R8: mid-period the active setting is frozen
    a_r8_int_hold: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MD_INT && !int_bound) |=> ($stable(act_div) && act_mode == MD_INT));

    a_r8_frac_hold: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MD_FRAC && !frac_bound) |=> ($stable(act_div) && act_mode == MD_FRAC));

endmodule

// File: rtl/clkdiv_int_core.sv
module clkdiv_int_core
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  div_mode_e        act_mode,
    input  logic [DIV_W-1:0] act_div,
    input  logic             load,
    input  div_mode_e        nxt_mode,
    input  logic [DIV_W-1:0] nxt_div,
    output logic             bound,
    output logic             tick,
    output logic             hi
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nx;
    logic [DIV_W-1:0] div_nx;
    logic             en;
    logic             run_nx;

    always_comb begin
        en     = (act_mode == MD_INT);
        bound  = en && (cnt == act_div - ONE);
        run_nx = load ? (nxt_mode == MD_INT) : en;
        div_nx = load ? nxt_div : act_div;
        cnt_nx = load ? '0 : cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
            hi   <= 1'b0;
        end else begin
            cnt  <= run_nx ? cnt_nx : '0;
            tick <= run_nx && (cnt_nx == '0);
            hi   <= run_nx && (cnt_nx < (div_nx >> 1));
        end
    end

    // R1: with a divisor of two or more, ticks are never adjacent
    a_r1_int_spacing: assert property (@(posedge clk) disable iff (rst)
        (en && act_div >= DIV_W'(2) && tick) |=> !tick);

    // R4: the high phase starts together with the tick
    a_r4_high_at_start: assert property (@(posedge clk) disable iff (rst)
        (en && act_div >= DIV_W'(2) && tick) |-> hi);

endmodule

// File: rtl/clkdiv_frac_core.sv
module clkdiv_frac_core
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  div_mode_e        act_mode,
    input  logic [DIV_W-1:0] act_div,
    input  logic             load,
    input  div_mode_e        nxt_mode,
    output logic             bound,
    output logic             tick,
    output logic             hi
);

    localparam int SUM_W = DIV_W + 1;

    logic [DIV_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic [DIV_W-1:0] acc_nx;
    logic             en;
    logic             run_nx;

    always_comb begin
        en     = (act_mode == MD_FRAC);
        sum    = {1'b0, acc} + {1'b0, act_div};
        bound  = en && sum[DIV_W];
        run_nx = load ? (nxt_mode == MD_FRAC) : en;
        // residue carries across a carry so the long-run ratio stays exact
        acc_nx = (run_nx && en) ? sum[DIV_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
            hi   <= 1'b0;
        end else begin
            acc  <= acc_nx;
            tick <= run_nx && load;
            hi   <= run_nx && acc_nx[DIV_W-1];
        end
    end

    // R6: ratio above two means no back-to-back ticks
    a_r6_frac_sparse: assert property (@(posedge clk) disable iff (rst)
        (en && !act_div[DIV_W-1] && tick) |=> !tick);

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_frac_en,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick_o,
    output logic             clk_o,
    output logic             err_zero_o,
    output logic             err_unsup_o
);

    div_mode_e        act_mode;
    div_mode_e        nxt_mode;
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] nxt_div;
    logic             load;
    logic             int_bound, int_tick, int_hi;
    logic             frac_bound, frac_tick, frac_hi;
    logic             bypass;
    logic             clk_div;

    clkdiv_ctrl #(.DIV_W(DIV_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_frac_en(cfg_frac_en),
        .cfg_div    (cfg_div),
        .int_bound  (int_bound),
        .frac_bound (frac_bound),
        .act_mode   (act_mode),
        .act_div    (act_div),
        .load       (load),
        .nxt_mode   (nxt_mode),
        .nxt_div    (nxt_div)
    );

    clkdiv_int_core #(.DIV_W(DIV_W)) int_i (
        .clk     (clk),
        .rst     (rst),
        .act_mode(act_mode),
        .act_div (act_div),
        .load    (load),
        .nxt_mode(nxt_mode),
        .nxt_div (nxt_div),
        .bound   (int_bound),
        .tick    (int_tick),
        .hi      (int_hi)
    );

    clkdiv_frac_core #(.DIV_W(DIV_W)) frac_i (
        .clk     (clk),
        .rst     (rst),
        .act_mode(act_mode),
        .act_div (act_div),
        .load    (load),
        .nxt_mode(nxt_mode),
        .bound   (frac_bound),
        .tick    (frac_tick),
        .hi      (frac_hi)
    );

    always_comb begin
        bypass      = (act_mode == MD_INT) && (act_div == DIV_W'(1));
        clk_div     = int_hi | frac_hi;
        tick_o      = int_tick | frac_tick;
        clk_o       = bypass ? clk : clk_div;
        err_zero_o  = (act_mode == MD_ZERO);
        err_unsup_o = (act_mode == MD_UNSUP);
    end

    // R5: zero divisor keeps the outputs quiet
    a_r5_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        err_zero_o |-> (!tick_o && !clk_div));

    // R7: unsupported mode keeps the outputs quiet
    a_r7_unsup_quiet: assert property (@(posedge clk) disable iff (rst)
        err_unsup_o |-> (!tick_o && !clk_div && !err_zero_o));

    // R2: pass-through setting ticks every cycle
    a_r2_bypass_tick: assert property (@(posedge clk) disable iff (rst)
        bypass |-> tick_o);

    // R6: only one core may drive a tick
    a_r6_one_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0({int_tick, frac_tick}));

endmodule

// File: tb/clkdiv_top_tb_top.sv
module clkdiv_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int FULL       = 1 << DIV_W;
    localparam int NVEC       = 10;

    // {frac_en, div, window cycles, expected ticks}
    localparam logic [40:0] VECS [NVEC] = '{
        {1'b0, 8'd2,   16'd256, 16'd128},
        {1'b0, 8'd3,   16'd255, 16'd85},
        {1'b0, 8'd5,   16'd250, 16'd50},
        {1'b0, 8'd7,   16'd252, 16'd36},
        {1'b0, 8'd255, 16'd255, 16'd1},
        {1'b1, 8'd3,   16'd256, 16'd3},
        {1'b1, 8'd100, 16'd256, 16'd100},
        {1'b1, 8'd77,  16'd256, 16'd77},
        {1'b1, 8'd127, 16'd256, 16'd127},
        {1'b0, 8'd6,   16'd252, 16'd42}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_frac_en = 1'b0;
    logic [DIV_W-1:0] cfg_div = 8'd4;
    logic             tick_o, clk_o, err_zero_o, err_unsup_o;

    int n_chk  = 0;
    int n_fail = 0;

    clkdiv_top #(.DIV_W(DIV_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_frac_en(cfg_frac_en),
        .cfg_div    (cfg_div),
        .tick_o     (tick_o),
        .clk_o      (clk_o),
        .err_zero_o (err_zero_o),
        .err_unsup_o(err_unsup_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_tick(input string req);
        int found = 0;
        for (int i = 0; i < 600 && !found; i++) begin
            step();
            if (tick_o) found = 1;
        end
        check({req, " tick found"}, found, 1);
    endtask

    // count ticks and clock-high samples over win cycles, starting at current sample
    task automatic measure(input int win, output int ticks, output int highs);
        ticks = 0;
        highs = 0;
        for (int i = 0; i < win; i++) begin
            if (i > 0) step();
            ticks += int'(tick_o);
            highs += int'(clk_o);
        end
    endtask

    task automatic apply(input logic f, input logic [DIV_W-1:0] d);
        cfg_frac_en = f;
        cfg_div     = d;
        repeat (300) step();
    endtask

    initial begin
        int t, h;
        // R9: reset state
        repeat (3) step();
        check("R9 tick in reset", int'(tick_o), 0);
        check("R9 clk in reset", int'(clk_o), 0);
        check("R9 flags in reset", int'(err_zero_o) + int'(err_unsup_o), 0);
        rst = 1'b0;
        step();
        check("R9 tick one cycle after release", int'(tick_o), 1);
        measure(12, t, h);
        check("R9 ticks after reset, div 4", t, 3);

        // R1 R3 R4 R6: table walk
        for (int v = 0; v < NVEC; v++) begin
            logic        vf;
            logic [7:0]  vd;
            int          vw, ve;
            vf = VECS[v][40];
            vd = VECS[v][39:32];
            vw = int'(VECS[v][31:16]);
            ve = int'(VECS[v][15:0]);
            apply(vf, vd);
            wait_tick(vf ? "R6" : "R1");
            measure(vw, t, h);
            if (vf) begin
                check("R6 frac tick count", t, ve);
            end else begin
                check(vd == 8'd2 ? "R3 int tick count" : "R1 int tick count", t, ve);
                check("R4 clock high cycles", h, (int'(vd) / 2) * ve);
            end
        end

        // R6: no adjacent ticks for the densest fractional setting
        apply(1'b1, 8'd127);
        begin
            int adj = 0;
            logic prev = 1'b0;
            for (int i = 0; i < FULL; i++) begin
                step();
                if (prev && tick_o) adj++;
                prev = tick_o;
            end
            check("R6 adjacent ticks", adj, 0);
        end

        // R2: pass-through
        apply(1'b0, 8'd1);
        measure(20, t, h);
        check("R2 tick every cycle", t, 20);
        @(posedge clk); #1;
        check("R2 clk_o high after rise", int'(clk_o), 1);
        step(); #1;
        check("R2 clk_o low after fall", int'(clk_o), 0);

        // R8: change mid-period waits for boundary
        apply(1'b0, 8'd16);
        wait_tick("R8");
        cfg_div = 8'd4;
        t = 0;
        for (int i = 1; i <= 15; i++) begin
            step();
            t += int'(tick_o);
        end
        check("R8 no early tick", t, 0);
        step();
        check("R8 old period ends at 16", int'(tick_o), 1);
        repeat (4) step();
        check("R8 new period of 4", int'(tick_o), 1);

        // R5: zero divisor, integer and fractional
        apply(1'b0, 8'd0);
        measure(100, t, h);
        check("R5 zero int flag", int'(err_zero_o), 1);
        check("R5 zero int ticks", t, 0);
        check("R5 zero int clk high", h, 0);
        apply(1'b1, 8'd0);
        measure(100, t, h);
        check("R5 zero frac flag", int'(err_zero_o), 1);
        check("R5 zero frac no unsup", int'(err_unsup_o), 0);
        check("R5 zero frac ticks", t, 0);

        // R7: unsupported gated setting
        apply(1'b1, 8'd133);
        measure(100, t, h);
        check("R7 unsup flag", int'(err_unsup_o), 1);
        check("R7 no zero flag", int'(err_zero_o), 0);
        check("R7 ticks", t + h, 0);

        // R1: recovery from error into integer mode
        apply(1'b0, 8'd9);
        check("R1 flags clear", int'(err_unsup_o) + int'(err_zero_o), 0);
        wait_tick("R1");
        measure(90, t, h);
        check("R1 div 9 ticks", t, 10);

        // R9: reset mid-run
        rst = 1'b1;
        step();
        check("R9 mid-run reset quiet", int'(tick_o) + int'(clk_o) + int'(err_zero_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule